// File: doc/BRIEF.md
# Scanline Sprite Compositor

This block assembles one horizontal video line at a time in a staging buffer that holds exactly one full scanline. The finished line is then streamed to a downstream video FIFO, so the FIFO only ever carries finished pixels. A start strobe latches a line number and a background colour. A control state machine then works through a fixed sequence. It paints the background into every buffer entry. It then selects the sprites from a small attribute table whose vertical extent covers the latched line. For each selected sprite, in table order, it reads that sprite's pixel row from a pixel memory and draws it into the buffer. A reserved pixel value is treated as transparent.

The pixel memory is a plain read port with a fixed latency. Because the compositor tracks every outstanding read, each returned pixel lands at the horizontal position it was requested for. The line leaves through a valid/ready stream and is marked on its final pixel. A one-cycle done pulse tells the video side that the next line may be requested.

Top module: `sprite_line_compositor`

## Requirements
- R1: After reset the block is idle: `pix_valid`, `mem_req`, `busy` and `done` are all low.
- R2: `start` is taken only while `busy` is low. `busy` is high from the cycle after an accepted `start` until the done pulse. A `start` seen while `busy` is high changes neither the line being built nor its background colour.
- R3: Every one of the LINE_W output pixels that no drawn sprite pixel covers equals the background colour latched at `start`.
- R4: Sprite i is drawn when `spr_en[i]` is 1 and its top row Y, its height H and the line L satisfy Y <= L < Y+H. Its pixel k (0 <= k < width W) is read from address base + (L-Y)*W + k and is placed at x = X+k. Each table field i sits at bits [i*FIELD_W +: FIELD_W] of its flat port.
- R5: A sprite pixel equal to 16'h0000 leaves the pixel beneath it unchanged.
- R6: Where opaque pixels of several sprites overlap, the sprite with the highest table index wins.
- R7: Sprite pixels at x >= LINE_W are clipped. No memory read is issued for them, and exactly one read is issued per unclipped pixel of each drawn sprite.
- R8: Read data is taken from `mem_data` at the second rising edge after the edge that sampled `mem_req`, and no read is issued while the line is being streamed.
- R9: The line leaves as LINE_W beats in order x = 0 .. LINE_W-1. While `pix_valid` is high and `pix_ready` is low, the beat and its data hold. `pix_last` is high only on beat LINE_W-1.
- R10: `done` is high for exactly the one cycle after the final beat is accepted, and at that point `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin composing one line |
| line_num | input | YW | Line number, latched at start |
| bg_color | input | PW | Background colour, latched at start |
| spr_en | input | NSPR | Per-sprite enable |
| spr_x | input | NSPR*XW | Sprite left edge |
| spr_y | input | NSPR*YW | Sprite top row |
| spr_w | input | NSPR*XW | Sprite width in pixels |
| spr_h | input | NSPR*YW | Sprite height in rows |
| spr_base | input | NSPR*AW | Pixel-memory address of sprite row 0 |
| mem_req | output | 1 | Pixel read request |
| mem_addr | output | AW | Pixel read address |
| mem_data | input | PW | Read data, two cycles after the request |
| pix_data | output | PW | Line pixel |
| pix_valid | output | 1 | Pixel beat valid |
| pix_ready | input | 1 | Downstream accepts the beat |
| pix_last | output | 1 | Final pixel of the line |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
`busy` is due one edge after an accepted `start`, and the bench reads it at the following falling edge. A read result is due two edges after its request. The bench memory model registers the address and then the data, and any misalignment shows up as wrong pixels at the port. Beats are counted at falling edges where `pix_valid` and `pix_ready` are both high, so each one is compared against the value computed for its x position. `done` is checked at the falling edge right after the final accepting edge, and again one cycle later to confirm it has dropped. Reads are counted per line to prove clipping.

// File: rtl/slc_pkg.sv
package slc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SCAN,
        ST_FETCH,
        ST_DRAIN,
        ST_STREAM
    } slc_state_e;
endpackage

// File: rtl/slc_line_buf.sv
module slc_line_buf #(
    parameter int PW    = 16,
    parameter int DEPTH = 32,
    localparam int XAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [XAW-1:0] wr_x,
    input  logic [PW-1:0]  wr_data,
    input  logic [XAW-1:0] rd_x,
    output logic [PW-1:0]  rd_data
);
    logic [PW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_x) < DEPTH)) begin
            mem_q[wr_x] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_x) < DEPTH) begin
            rd_data = mem_q[rd_x];
        end
    end
endmodule

// File: rtl/slc_hit_finder.sv
module slc_hit_finder #(
    parameter int NSPR = 4,
    parameter int YW   = 10
) (
    input  logic [YW-1:0]      line,
    input  logic [NSPR-1:0]    spr_en,
    input  logic [NSPR*YW-1:0] spr_y,
    input  logic [NSPR*YW-1:0] spr_h,
    output logic [NSPR-1:0]    hit
);
    for (genvar i = 0; i < NSPR; i++) begin : g_spr
        logic [YW:0] top_e;
        logic [YW:0] bot_e;
        logic [YW:0] line_e;
        assign top_e  = {1'b0, spr_y[i*YW +: YW]};
        assign bot_e  = top_e + {1'b0, spr_h[i*YW +: YW]};
        assign line_e = {1'b0, line};
        assign hit[i] = spr_en[i] && (line_e >= top_e) && (line_e < bot_e);
    end
endmodule

// File: rtl/slc_fetch_pipe.sv
module slc_fetch_pipe #(
    parameter int          PW    = 16,
    parameter int          XAW   = 5,
    parameter int          LAT   = 2,
    parameter logic [15:0] TRANS = 16'h0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue,
    input  logic [XAW-1:0] issue_x,
    input  logic [PW-1:0]  mem_data,
    output logic           wr_en,
    output logic [XAW-1:0] wr_x,
    output logic [PW-1:0]  wr_data,
    output logic           empty
);
    logic [LAT-1:0] v_d, v_q;
    logic [XAW-1:0] x_d [LAT];
    logic [XAW-1:0] x_q [LAT];

    always_comb begin
        v_d[0] = issue;
        x_d[0] = issue_x;
        for (int i = 1; i < LAT; i++) begin
            v_d[i] = v_q[i-1];
            x_d[i] = x_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
        for (int i = 0; i < LAT; i++) begin
            x_q[i] <= x_d[i];
        end
    end

    assign wr_en   = v_q[LAT-1] && (mem_data != PW'(TRANS));
    assign wr_x    = x_q[LAT-1];
    assign wr_data = mem_data;
    assign empty   = (v_q == '0);
endmodule

// File: rtl/sprite_line_compositor.sv
module sprite_line_compositor
    import slc_pkg::*;
#(
    parameter int          PW      = 16,
    parameter int          LINE_W  = 32,
    parameter int          NSPR    = 4,
    parameter int          XW      = 8,
    parameter int          YW      = 10,
    parameter int          AW      = 16,
    parameter int          MEM_LAT = 2,
    parameter logic [15:0] TRANS   = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [YW-1:0]     line_num,
    input  logic [PW-1:0]     bg_color,
    input  logic [NSPR-1:0]   spr_en,
    input  logic [NSPR*XW-1:0] spr_x,
    input  logic [NSPR*YW-1:0] spr_y,
    input  logic [NSPR*XW-1:0] spr_w,
    input  logic [NSPR*YW-1:0] spr_h,
    input  logic [NSPR*AW-1:0] spr_base,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [PW-1:0]     mem_data,
    output logic [PW-1:0]     pix_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic              pix_last,
    output logic              busy,
    output logic              done
);
    localparam int XAW = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int IW  = $clog2(NSPR + 1);
    localparam logic [XAW-1:0] X_LAST = XAW'(LINE_W - 1);

    typedef struct packed {
        slc_state_e      state;
        logic [YW-1:0]   line;
        logic [PW-1:0]   bg;
        logic [NSPR-1:0] hit;
        logic [IW-1:0]   idx;
        logic [XW-1:0]   col;
        logic [XAW-1:0]  xcnt;
        logic            done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [NSPR-1:0] hit_now;
    logic            cur_hit;
    logic [XW-1:0]   cur_x, cur_w;
    logic [YW-1:0]   cur_y;
    logic [AW-1:0]   cur_base;
    logic [XW:0]     scr_x;
    logic [YW-1:0]   row;
    logic [YW+XW-1:0] row_off;

    logic            fill_we;
    logic            issue;
    logic            pipe_we, pipe_empty;
    logic [XAW-1:0]  pipe_x;
    logic [PW-1:0]   pipe_data;
    logic            buf_we;
    logic [XAW-1:0]  buf_wx;
    logic [PW-1:0]   buf_wd, buf_rd;

    slc_hit_finder #(.NSPR(NSPR), .YW(YW)) u_hit (
        .line   (c_q.line),
        .spr_en (spr_en),
        .spr_y  (spr_y),
        .spr_h  (spr_h),
        .hit    (hit_now)
    );

    // Attributes of the sprite currently being fetched
    always_comb begin
        cur_hit  = 1'b0;
        cur_x    = '0;
        cur_w    = '0;
        cur_y    = '0;
        cur_base = '0;
        for (int i = 0; i < NSPR; i++) begin
            if (c_q.idx == IW'(i)) begin
                cur_hit  = c_q.hit[i];
                cur_x    = spr_x[i*XW +: XW];
                cur_w    = spr_w[i*XW +: XW];
                cur_y    = spr_y[i*YW +: YW];
                cur_base = spr_base[i*AW +: AW];
            end
        end
        scr_x   = {1'b0, cur_x} + {1'b0, c_q.col};
        row     = c_q.line - cur_y;
        row_off = row * cur_w;
    end

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        fill_we  = 1'b0;
        issue    = 1'b0;
        mem_addr = cur_base + AW'(row_off) + AW'(c_q.col);
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.state = ST_FILL;
                    c_d.line  = line_num;
                    c_d.bg    = bg_color;
                    c_d.xcnt  = '0;
                end
            end
            ST_FILL: begin
                fill_we = 1'b1;
                if (c_q.xcnt == X_LAST) begin
                    c_d.xcnt  = '0;
                    c_d.state = ST_SCAN;
                end else begin
                    c_d.xcnt = c_q.xcnt + 1'b1;
                end
            end
            ST_SCAN: begin
                c_d.hit   = hit_now;
                c_d.idx   = '0;
                c_d.col   = '0;
                c_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                if (c_q.idx == IW'(NSPR)) begin
                    c_d.state = ST_DRAIN;
                end else if (cur_hit && (c_q.col < cur_w) &&
                             (scr_x < (XW+1)'(LINE_W))) begin
                    issue     = 1'b1;
                    c_d.col   = c_q.col + 1'b1;
                end else begin
                    c_d.idx = c_q.idx + 1'b1;
                    c_d.col = '0;
                end
            end
            ST_DRAIN: begin
                if (pipe_empty) begin
                    c_d.xcnt  = '0;
                    c_d.state = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (pix_ready) begin
                    if (c_q.xcnt == X_LAST) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.xcnt = c_q.xcnt + 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    slc_fetch_pipe #(.PW(PW), .XAW(XAW), .LAT(MEM_LAT), .TRANS(TRANS)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .issue_x  (XAW'(scr_x)),
        .mem_data (mem_data),
        .wr_en    (pipe_we),
        .wr_x     (pipe_x),
        .wr_data  (pipe_data),
        .empty    (pipe_empty)
    );

    assign buf_we = fill_we | pipe_we;
    assign buf_wx = fill_we ? c_q.xcnt : pipe_x;
    assign buf_wd = fill_we ? c_q.bg : pipe_data;

    slc_line_buf #(.PW(PW), .DEPTH(LINE_W)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_x    (buf_wx),
        .wr_data (buf_wd),
        .rd_x    (c_q.xcnt),
        .rd_data (buf_rd)
    );

    assign mem_req   = issue;
    assign pix_valid = (c_q.state == ST_STREAM);
    assign pix_data  = buf_rd;
    assign pix_last  = pix_valid && (c_q.xcnt == X_LAST);
    assign busy      = (c_q.state != ST_IDLE);
    assign done      = c_q.done;
endmodule

// File: rtl/sprite_line_compositor_chk.sv
module sprite_line_compositor_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_req,
    input logic          pix_valid,
    input logic          pix_ready,
    input logic [PW-1:0] pix_data,
    input logic          pix_last,
    input logic          done
);
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_no_req_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !mem_req);

    assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));

    assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |-> pix_valid);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !pix_valid));
endmodule

bind sprite_line_compositor sprite_line_compositor_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_req   (mem_req),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_data  (pix_data),
    .pix_last  (pix_last),
    .done      (done)
);

// File: tb/tb_sprite_line_compositor.sv
module tb_sprite_line_compositor;
    localparam int PW = 16, LINE_W = 32, NSPR = 4, XW = 8, YW = 10, AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              start = 1'b0;
    logic [YW-1:0]     line_num = '0;
    logic [PW-1:0]     bg_color = '0;
    logic [NSPR-1:0]   spr_en = '0;
    logic [NSPR*XW-1:0] spr_x;
    logic [NSPR*YW-1:0] spr_y;
    logic [NSPR*XW-1:0] spr_w;
    logic [NSPR*YW-1:0] spr_h;
    logic [NSPR*AW-1:0] spr_base;
    logic              mem_req;
    logic [AW-1:0]     mem_addr;
    logic [PW-1:0]     mem_data;
    logic [PW-1:0]     pix_data;
    logic              pix_valid;
    logic              pix_ready = 1'b0;
    logic              pix_last;
    logic              busy;
    logic              done;

    int t_x [NSPR];
    int t_y [NSPR];
    int t_w [NSPR];
    int t_h [NSPR];
    int t_b [NSPR];

    always_comb begin
        for (int i = 0; i < NSPR; i++) begin
            spr_x[i*XW +: XW]    = XW'(t_x[i]);
            spr_y[i*YW +: YW]    = YW'(t_y[i]);
            spr_w[i*XW +: XW]    = XW'(t_w[i]);
            spr_h[i*YW +: YW]    = YW'(t_h[i]);
            spr_base[i*AW +: AW] = AW'(t_b[i]);
        end
    end

    sprite_line_compositor dut (
        .clk(clk), .rst_n(rst_n), .start(start), .line_num(line_num),
        .bg_color(bg_color), .spr_en(spr_en), .spr_x(spr_x), .spr_y(spr_y),
        .spr_w(spr_w), .spr_h(spr_h), .spr_base(spr_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_last(pix_last), .busy(busy), .done(done)
    );

    // Pixel memory content: low nibble F is the transparent value 0
    function automatic logic [PW-1:0] memval(input int a);
        logic [15:0] av;
        av = 16'(a);
        if (av[3:0] == 4'hF) return 16'h0000;
        return {4'h8, av[11:0]};
    endfunction

    // Two-cycle read model
    logic [AW-1:0] m_a1;
    logic [PW-1:0] m_d2;
    always @(posedge clk) begin
        m_a1 <= mem_addr;
        m_d2 <= memval(int'(m_a1));
    end
    assign mem_data = m_d2;

    int req_cnt = 0;
    always @(posedge clk) if (rst_n && mem_req) req_cnt <= req_cnt + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int ref_pix(input int line, input int bg, input int x);
        int v = bg;
        for (int s = 0; s < NSPR; s++) begin
            if (spr_en[s] && line >= t_y[s] && line < t_y[s] + t_h[s] &&
                x >= t_x[s] && x < t_x[s] + t_w[s]) begin
                int p = int'(memval(t_b[s] + (line - t_y[s]) * t_w[s] + (x - t_x[s])));
                if (p != 0) v = p;
            end
        end
        return v;
    endfunction

    function automatic int ref_reqs(input int line);
        int n = 0;
        for (int s = 0; s < NSPR; s++) begin
            if (spr_en[s] && line >= t_y[s] && line < t_y[s] + t_h[s] && t_x[s] < LINE_W) begin
                n += (t_w[s] < LINE_W - t_x[s]) ? t_w[s] : LINE_W - t_x[s];
            end
        end
        return n;
    endfunction

    // Compose one line and compare every beat. bp=1 applies backpressure,
    // poke=1 pulses start again with other values while busy.
    task automatic run_line(input int line, input int bg, input bit bp, input bit poke,
                            input string tag);
        int base_req, n, cyc;
        @(negedge clk);
        line_num = YW'(line);
        bg_color = PW'(bg);
        base_req = req_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        n = 0;
        cyc = 0;
        while (n < LINE_W && cyc < 2000) begin
            if (poke && cyc == 5) begin
                line_num = YW'(line + 1);
                bg_color = PW'(bg ^ 16'hFFFF);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            pix_ready = bp ? (cyc % 3 != 0) : 1'b1;
            if (pix_valid && pix_ready) begin
                int e = ref_pix(line, bg, n);
                check(pix_data === PW'(e), $sformatf("%s pixel x=%0d", tag, n), int'(pix_data), e);
                check(pix_last === (n == LINE_W - 1), "R9 last flag", int'(pix_last),
                      int'(n == LINE_W - 1));
                n++;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        pix_ready = 1'b0;
        check(n == LINE_W, "R9 beat count", n, LINE_W);
        check(done === 1'b1 && busy === 1'b0, "R10 done after last beat", int'({done, busy}), 2);
        check(req_cnt - base_req == ref_reqs(line), "R7 read count", req_cnt - base_req,
              ref_reqs(line));
        @(negedge clk);
        check(done === 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic clear_table();
        spr_en = '0;
        for (int i = 0; i < NSPR; i++) begin
            t_x[i] = 0; t_y[i] = 0; t_w[i] = 0; t_h[i] = 0; t_b[i] = 0;
        end
    endtask

    task automatic t_reset();
        check(pix_valid === 1'b0 && mem_req === 1'b0 && busy === 1'b0 && done === 1'b0,
              "R1 reset state", int'({pix_valid, mem_req, busy, done}), 0);
    endtask

    task automatic t_background();
        clear_table();
        run_line(5, 16'h1234, 1'b0, 1'b0, "R3 background");
    endtask

    task automatic t_single();
        clear_table();
        t_x[0] = 4; t_y[0] = 2; t_w[0] = 6; t_h[0] = 4; t_b[0] = 'h100;
        spr_en = 4'b0001;
        run_line(3, 16'h0421, 1'b0, 1'b0, "R4 R8 single sprite");
        run_line(2, 16'h0421, 1'b0, 1'b0, "R4 top row");
        run_line(6, 16'h0421, 1'b0, 1'b0, "R4 row below extent");
        run_line(1, 16'h0421, 1'b0, 1'b0, "R4 row above extent");
    endtask

    task automatic t_overlap();
        clear_table();
        t_x[0] = 2; t_y[0] = 0; t_w[0] = 10; t_h[0] = 8; t_b[0] = 'h300;
        t_x[1] = 7; t_y[1] = 1; t_w[1] = 6;  t_h[1] = 8; t_b[1] = 'h400;
        t_x[3] = 9; t_y[3] = 3; t_w[3] = 3;  t_h[3] = 2; t_b[3] = 'h500;
        spr_en = 4'b1011;
        run_line(4, 16'h0777, 1'b0, 1'b0, "R6 overlap priority");
    endtask

    task automatic t_transparent();
        clear_table();
        t_x[0] = 0;  t_y[0] = 0; t_w[0] = 20; t_h[0] = 4; t_b[0] = 'h600;
        t_x[2] = 3;  t_y[2] = 0; t_w[2] = 8;  t_h[2] = 4; t_b[2] = 'h20B;
        spr_en = 4'b0101;
        run_line(0, 16'h0111, 1'b0, 1'b0, "R5 transparency over sprite");
        spr_en = 4'b0100;
        run_line(0, 16'h0111, 1'b0, 1'b0, "R5 transparency over background");
    endtask

    task automatic t_clip();
        clear_table();
        t_x[0] = 28; t_y[0] = 0; t_w[0] = 10; t_h[0] = 2; t_b[0] = 'h700;
        t_x[1] = 40; t_y[1] = 0; t_w[1] = 5;  t_h[1] = 2; t_b[1] = 'h800;
        t_x[2] = 31; t_y[2] = 1; t_w[2] = 1;  t_h[2] = 1; t_b[2] = 'h900;
        spr_en = 4'b0111;
        run_line(1, 16'h0222, 1'b0, 1'b0, "R7 right-edge clip");
    endtask

    task automatic t_backpressure();
        clear_table();
        t_x[1] = 10; t_y[1] = 0; t_w[1] = 12; t_h[1] = 3; t_b[1] = 'hA00;
        spr_en = 4'b0010;
        run_line(2, 16'h0333, 1'b1, 1'b0, "R9 backpressure");
    endtask

    task automatic t_ignore_start();
        clear_table();
        t_x[0] = 1; t_y[0] = 5; t_w[0] = 4; t_h[0] = 1; t_b[0] = 'hB00;
        spr_en = 4'b0001;
        run_line(5, 16'h0444, 1'b0, 1'b1, "R2 start ignored while busy");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_background();
        t_single();
        t_overlap();
        t_transparent();
        t_clip();
        t_backpressure();
        t_ignore_start();
        finish_run();
    end
endmodule